// File: doc/BRIEF.md
# Self-healing ring counter

This block is an N-stage shift register that walks a single set bit through its stages, one position per enabled clock, so that its output is always one of the N one-hot codes. The output drives 1-out-of-N polling selects directly: stage k high means device k has its turn. Decoding and arbitration between devices belong to the logic that consumes the select.

A plain ring counter copies its last stage back into its first stage. One upset bit then traps it in a wrong loop for good. This block instead builds the bit entering stage 0 from the state. A 1 enters only when every stage except the last is clear. Any pattern (all zeros, several set bits, a stray bit) therefore drains back into the one-hot loop within N enabled clocks, with no help from outside.

Control has three named modes, decoded each cycle from the two control inputs. CTL_INIT (reset high) loads the first one-hot code. CTL_HOLD (reset low, enable low) keeps every stage. CTL_STEP (reset low, enable high) shifts by one stage. Reset always wins, so the transitions are: any mode to CTL_INIT on reset; CTL_INIT or CTL_HOLD to CTL_STEP when enable rises; CTL_STEP to CTL_HOLD when enable falls. Inside CTL_STEP the legal ring states are ONEHOT_0 through ONEHOT_(N-1), visited in that order and wrapping to ONEHOT_0. Every other pattern is an illegal state and flows toward that loop.

Top module: `self_heal_ring`

## Requirements
- R1: When `rst` is high at a clock edge, `ring_q` equals 1 (only stage 0 set) after that edge.
- R2: When `rst` is low and `en` is low at an edge, `ring_q` keeps its value, whether that value is legal or not.
- R3: On an edge with `rst` low and `en` high, bit i+1 of `ring_q` takes the old bit i for every i from 0 to N-2, so from reset the outputs are 1, 2, 4, ..., 2^(N-1), then 1 again.
- R4: On such an edge, bit 0 of `ring_q` becomes 1 exactly when old bits 0 to N-2 were all 0, and becomes 0 otherwise; old bit N-1 does not affect it.
- R5: Starting from any of the 2^N values, `ring_q` holds exactly one set bit after at most N enabled clocks.
- R6: Once `ring_q` holds exactly one set bit, every later enabled clock leaves exactly one set bit.
- R7: Reset takes priority over enable: with `rst` high and `en` low, the edge still loads 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; all state changes on its rising edge |
| rst | input | 1 | Synchronous reset, active high |
| en | input | 1 | Step enable, active high |
| ring_q | output | N | Stage contents; one-hot poll select in normal running |

## Verification
The illegal patterns are the hardest part to test. Reset, hold and step only ever produce the one-hot codes, so no port sequence can reach the patterns that the recovery requirement is about. The bench holds reset for one edge, then overrides the stage register with each of the 2^N patterns while reset is still high, releases the override, and steps the counter. Each step is compared against an arithmetic next-state model, and the bench counts how many enabled clocks pass before a single set bit appears. Reset is high during the override, so the clocked properties never see the injected value as a transition.

// File: rtl/self_heal_ring_pkg.sv
package self_heal_ring_pkg;

    // Control mode decoded once per cycle from reset and enable.
    typedef enum logic [1:0] {
        CTL_INIT = 2'd0,
        CTL_HOLD = 2'd1,
        CTL_STEP = 2'd2
    } ring_ctl_e;

    // Number of set bits in a vector of up to 64 stages.
    function automatic int unsigned set_bit_count(input logic [63:0] vec);
        int unsigned total;
        total = 0;
        for (int i = 0; i < 64; i++) begin
            total += int'(vec[i]);
        end
        return total;
    endfunction

endpackage

// File: rtl/ring_ctl_decode.sv
module ring_ctl_decode
    import self_heal_ring_pkg::*;
(
    input  logic      rst,
    input  logic      en,
    output ring_ctl_e mode
);

    // Reset dominates; enable only matters out of reset.
    always_comb begin
        unique case ({rst, en})
            2'b10,
            2'b11:   mode = CTL_INIT;
            2'b01:   mode = CTL_STEP;
            default: mode = CTL_HOLD;
        endcase
    end

endmodule

// File: rtl/ring_feedback.sv
module ring_feedback #(
    parameter int N = 4
) (
    input  logic [N-1:0] stage_q,
    output logic         serial_in
);

    localparam int LOW_W = N - 1;

    logic [LOW_W-1:0] low_stages;

    // The last stage is deliberately left out of the feedback term.
    assign low_stages = stage_q[LOW_W-1:0];

    always_comb begin
        serial_in = (low_stages == '0);
    end

endmodule

// File: rtl/ring_stage_reg.sv
module ring_stage_reg
    import self_heal_ring_pkg::*;
#(
    parameter int N = 4
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          en,
    input  ring_ctl_e     mode,
    input  logic          serial_in,
    output logic [N-1:0]  stage_q
);

    localparam logic [N-1:0] SEED = N'(1);

    logic [N-1:0] state_q;
    logic [N-1:0] state_d;

    // Next-state selection per control mode.
    always_comb begin
        unique case (mode)
            CTL_INIT: state_d = SEED;
            CTL_STEP: state_d = {state_q[N-2:0], serial_in};
            CTL_HOLD: state_d = state_q;
            default:  state_d = state_q;
        endcase
    end

    // State register.
    always_ff @(posedge clk) begin
        state_q <= state_d;
    end

    // Output process.
    always_comb begin
        stage_q = state_q;
    end

    p_hold_r2: assert property (@(posedge clk) disable iff (rst)
        !en |=> $stable(state_q));

    p_shift_r3: assert property (@(posedge clk) disable iff (rst)
        en |=> state_q[N-1:1] == $past(state_q[N-2:0]));

    p_feed_r4: assert property (@(posedge clk) disable iff (rst)
        en |=> state_q[0] == ($past(state_q[N-2:0]) == '0));

endmodule

// File: rtl/ring_legal_mon.sv
module ring_legal_mon
    import self_heal_ring_pkg::*;
#(
    parameter int N = 4
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         en,
    input  logic [N-1:0] stage_q
);

    localparam int CNT_W = $clog2(N + 2) + 1;
    localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

    logic             legal;
    logic [CNT_W-1:0] illegal_steps;

    always_comb begin
        legal = (set_bit_count(64'(stage_q)) == 1);
    end

    // Enabled clocks spent so far in an illegal pattern.
    always_ff @(posedge clk) begin
        if (rst) begin
            illegal_steps <= '0;
        end else if (en) begin
            if (legal) begin
                illegal_steps <= '0;
            end else if (illegal_steps != CNT_MAX) begin
                illegal_steps <= illegal_steps + 1'b1;
            end
        end
    end

    p_recover_r5: assert property (@(posedge clk) disable iff (rst)
        !legal |-> illegal_steps < CNT_W'(N));

    p_legal_keep_r6: assert property (@(posedge clk) disable iff (rst)
        legal && en |=> legal);

endmodule

// File: rtl/self_heal_ring.sv
module self_heal_ring
    import self_heal_ring_pkg::*;
#(
    parameter int N = 4
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         en,
    output logic [N-1:0] ring_q
);

    initial begin
        if (N < 2 || N > 64) $error("self_heal_ring: N must lie in 2..64");
    end

    ring_ctl_e    mode;
    logic         serial_in;
    logic [N-1:0] stage_q;

    ring_ctl_decode u_ctl (
        .rst  (rst),
        .en   (en),
        .mode (mode)
    );

    ring_feedback #(.N(N)) u_fb (
        .stage_q   (stage_q),
        .serial_in (serial_in)
    );

    ring_stage_reg #(.N(N)) u_reg (
        .clk       (clk),
        .rst       (rst),
        .en        (en),
        .mode      (mode),
        .serial_in (serial_in),
        .stage_q   (stage_q)
    );

    ring_legal_mon #(.N(N)) u_mon (
        .clk     (clk),
        .rst     (rst),
        .en      (en),
        .stage_q (stage_q)
    );

    assign ring_q = stage_q;

endmodule

// File: tb/self_heal_ring_bench.sv
module self_heal_ring_bench;

    localparam int N = 4;
    localparam int PATTERNS = 1 << N;

    logic         clk;
    logic         rst;
    logic         en;
    logic [N-1:0] ring_q;

    int checks;
    int errors;
    bit done;

    self_heal_ring #(.N(N)) u_self_heal_ring (
        .clk    (clk),
        .rst    (rst),
        .en     (en),
        .ring_q (ring_q)
    );

    initial clk = 1'b0;
    always #4 clk = ~clk;

    function automatic logic [N-1:0] model_next(input logic [N-1:0] s);
        logic [N-1:0] low_mask;
        low_mask = {N{1'b1}} >> 1;
        return ((s << 1) & {N{1'b1}}) | N'(((s & low_mask) == 0) ? 1 : 0);
    endfunction

    function automatic int ones(input logic [N-1:0] s);
        int c;
        c = 0;
        for (int i = 0; i < N; i++) c += int'(s[i]);
        return c;
    endfunction

    task automatic check(input string req, input logic [N-1:0] got, input logic [N-1:0] exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s: ring_q=%b expected %b", req, got, exp);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        @(negedge clk);
    endtask

    // Reset edge, then overwrite the stage register while reset is still high.
    task automatic inject(input logic [N-1:0] pat);
        rst = 1'b1;
        en  = 1'b0;
        tick();
        force u_self_heal_ring.u_reg.state_q = pat;
        tick();
        release u_self_heal_ring.u_reg.state_q;
        rst = 1'b0;
    endtask

    initial begin
        checks = 0;
        errors = 0;
        done   = 1'b0;
        rst    = 1'b1;
        en     = 1'b1;
        @(negedge clk);
        tick();
        check("R1", ring_q, N'(1));

        // R3: legal walk from reset, two full turns
        rst = 1'b0;
        for (int k = 1; k <= 2 * N; k++) begin
            tick();
            check("R3", ring_q, N'(1) << (k % N));
        end

        // R2: hold on a legal value
        en = 1'b0;
        begin
            logic [N-1:0] held;
            held = ring_q;
            for (int k = 0; k < 3; k++) begin
                tick();
                check("R2", ring_q, held);
            end
        end

        // R7: reset with enable low still loads the seed
        tick();
        en  = 1'b1;
        tick();
        rst = 1'b1;
        en  = 1'b0;
        tick();
        check("R7", ring_q, N'(1));

        // Exhaustive sweep over every stage pattern
        for (int p = 0; p < PATTERNS; p++) begin
            logic [N-1:0] exp;
            int           steps;
            bit           seen;
            inject(N'(p));
            // R2 on an arbitrary, possibly illegal, pattern
            tick();
            check("R2", ring_q, N'(p));
            en    = 1'b1;
            exp   = N'(p);
            steps = 0;
            seen  = (ones(exp) == 1);
            for (int k = 0; k < N; k++) begin
                tick();
                exp = model_next(exp);
                check("R4", ring_q, exp);
                if (!seen) begin
                    steps++;
                    if (ones(ring_q) == 1) seen = 1'b1;
                end
            end
            checks++;
            if (!seen || steps > N) begin
                errors++;
                $display("FAIL R5: pattern %b took %0d clocks, expected at most %0d", N'(p), steps, N);
            end
            for (int k = 0; k < N + 1; k++) begin
                tick();
                checks++;
                if (ones(ring_q) != 1) begin
                    errors++;
                    $display("FAIL R6: ring_q=%b has %0d set bits, expected 1", ring_q, ones(ring_q));
                end
            end
            en = 1'b0;
        end

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: run did not finish, expected completion");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

endmodule